// File: doc/BRIEF.md
# Parallel Flash Bus Front-End

This block sits between the pins of a 16-bit parallel NOR-style memory and its core. It turns the active-low chip-enable, output-enable and write-enable pins into one read condition and one write condition, and it turns a byte-width select pin into a bus-width mode. It decides which of the sixteen data lanes are driven, so the pad ring receives a separate output value and a separate drive-enable for each lane. In byte mode the top data lane becomes an input that carries the half-word address bit. A synchronous active-high reset silences the bus.

Array data comes from a synchronous read port. The pin address is forwarded to this port unchanged, and the word comes back one clock later. The block then holds the data in an output latch. It counts the cycles for which the access key (width mode, word address and half-word bit) has not changed. The latch is refreshed only after a configurable access time. Once a further configurable margin has elapsed, the block goes to sleep and freezes the latch, so the last data stays on the bus even if the array contents change underneath. Any change of the key wakes the block and starts the access time again.

Top module: `pflash_frontend`

## Requirements
- R1: With reset low, ce_n=0, oe_n=0, we_n=1 and byte_n=1 (word mode), dq_oe is 16'hFFFF.
- R2: With the same read controls and byte_n=0 (byte mode), dq_oe is 16'h00FF. Lanes 8 to 14 are never driven, and lane 15 is never driven because it is an input.
- R3: In byte mode the half-word bit is dq_in[15]. A value of 0 makes dq_out[7:0] show bits 7:0 of the addressed word, and a value of 1 shows bits 15:8. In byte mode dq_out[15:8] reads zero.
- R4: Whenever oe_n=1, ce_n=1 or we_n=0, dq_oe is all zero.
- R5: wr_strobe is high exactly when reset is low, ce_n=0, we_n=0 and oe_n=1. wr_data equals dq_in in word mode and {8'h00, dq_in[7:0]} in byte mode.
- R6: While rst is high, dq_oe is zero and wr_strobe is low. The edge on which rst is high clears the output latch to zero and holds the stable count at zero.
- R7: The stable count is cleared on an edge that sees a key different from the one seen at the previous edge. Otherwise it rises by one per edge and saturates at ACC_CYC+SLEEP_MARGIN. The output latch loads the array word (steered per R3) on an edge where the key is unchanged and the count is at least ACC_CYC and not yet saturated.
- R8: asleep is high exactly when the stable count has saturated. While it is high the output latch does not change, even if the array word changes.
- R9: A key change (word address, dq_in[15] in byte mode, or byte_n) while asleep drops asleep on that same edge.
- R10: arr_addr always equals addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also silences the bus |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| byte_n | input | 1 | 1 selects word mode, 0 selects byte mode |
| addr | input | AW | Word address from the pins |
| dq_in | input | 16 | Data lanes as seen from the pins; lane 15 is the half-word bit in byte mode |
| dq_out | output | 16 | Output latch value presented to the lanes |
| dq_oe | output | 16 | Per-lane drive enable |
| arr_addr | output | AW | Read address to the array |
| arr_rdata | input | 16 | Array word, valid one clock after arr_addr |
| wr_strobe | output | 1 | Write condition flagged to the command logic |
| wr_data | output | 16 | Write data, width-adjusted |
| asleep | output | 1 | Sleep state; the output latch is frozen |

## Verification
Two events can land on one edge: the key change that ends an access and the edge on which the stable count would saturate and put the block to sleep. The bench holds an address for lengths running from just below to just above the sleep threshold before each change, and it also toggles the half-word lane in byte mode. This makes a wake-up coincide with the sleep entry. A reset arriving in the middle of an open read is a second collision. A behavioural cycle model in the bench predicts the latch, the sleep flag and the lane enables on every cycle, and any disagreement is reported.

// File: rtl/pff_pkg.sv
package pff_pkg;

    localparam int DQ_W   = 16;
    localparam int BYTE_W = 8;

    // Decoded view of the control pins for one cycle.
    typedef struct packed {
        logic rd_en;      // read: lanes may be driven
        logic wr_en;      // write strobe toward the command logic
        logic byte_mode;  // narrow bus, lane 15 is an address input
    } bus_ctl_t;

    // Narrow the array word to the selected half when in byte mode.
    function automatic logic [DQ_W-1:0] steer_word(
        input logic [DQ_W-1:0] w,
        input logic            byte_mode,
        input logic            half_sel
    );
        if (!byte_mode)
            return w;
        return {{(DQ_W-BYTE_W){1'b0}}, half_sel ? w[DQ_W-1:BYTE_W] : w[BYTE_W-1:0]};
    endfunction

endpackage

// File: rtl/pff_ctl_decode.sv
module pff_ctl_decode
    import pff_pkg::*;
(
    input  logic     rst,
    input  logic     ce_n,
    input  logic     oe_n,
    input  logic     we_n,
    input  logic     byte_n,
    output bus_ctl_t ctl
);

    always_comb begin
        ctl.rd_en     = !rst && !ce_n && !oe_n && we_n;
        ctl.wr_en     = !rst && !ce_n && !we_n && oe_n;
        ctl.byte_mode = !byte_n;
    end

endmodule

// File: rtl/pff_sleep_timer.sv
module pff_sleep_timer #(
    parameter int KW        = 22,
    parameter int ACC_CYC   = 4,
    parameter int SLEEP_CYC = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [KW-1:0] key,
    output logic          load_ok,
    output logic          asleep
);

    localparam int CW = $clog2(SLEEP_CYC + 1);

    logic [KW-1:0] key_q;
    logic [CW-1:0] cnt_q;
    logic          same;

    assign same = (key == key_q);

    always_ff @(posedge clk) begin
        key_q <= key;
        if (rst)
            cnt_q <= '0;
        else if (!same)
            cnt_q <= '0;
        else if (cnt_q != CW'(SLEEP_CYC))
            cnt_q <= cnt_q + 1'b1;
    end

    assign asleep  = (cnt_q == CW'(SLEEP_CYC));
    assign load_ok = same && (cnt_q >= CW'(ACC_CYC)) && !asleep;

    // A new key while asleep must wake the block on the same edge.
    assert_wake_on_key_R9: assert property (@(posedge clk) disable iff (rst)
        (asleep && !same) |=> !asleep);

endmodule

// File: rtl/pff_lane_steer.sv
module pff_lane_steer
    import pff_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            rd_en,
    input  logic            byte_mode,
    input  logic            half_sel,
    input  logic            load_ok,
    input  logic            hold,
    input  logic [DQ_W-1:0] arr_rdata,
    output logic [DQ_W-1:0] dq_out,
    output logic [DQ_W-1:0] dq_oe
);

    logic [DQ_W-1:0] dat_q;

    always_ff @(posedge clk) begin
        if (rst)
            dat_q <= '0;
        else if (load_ok)
            dat_q <= steer_word(arr_rdata, byte_mode, half_sel);
    end

    assign dq_out = dat_q;

    for (genvar g = 0; g < DQ_W; g++) begin : g_lane
        if (g < BYTE_W) begin : g_low
            assign dq_oe[g] = rd_en;
        end else begin : g_high
            assign dq_oe[g] = rd_en & ~byte_mode;
        end
    end

    // Sleep freezes the latch.
    assert_sleep_latch_R8: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(dat_q));

    // Upper lanes stay released on a narrow bus.
    assert_upper_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        byte_mode |-> (dq_oe[DQ_W-1:BYTE_W] == '0));

endmodule

// File: rtl/pflash_frontend.sv
module pflash_frontend
    import pff_pkg::*;
#(
    parameter int AW           = 20,
    parameter int ACC_CYC      = 4,
    parameter int SLEEP_MARGIN = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ce_n,
    input  logic            oe_n,
    input  logic            we_n,
    input  logic            byte_n,
    input  logic [AW-1:0]   addr,
    input  logic [DQ_W-1:0] dq_in,
    output logic [DQ_W-1:0] dq_out,
    output logic [DQ_W-1:0] dq_oe,
    output logic [AW-1:0]   arr_addr,
    input  logic [DQ_W-1:0] arr_rdata,
    output logic            wr_strobe,
    output logic [DQ_W-1:0] wr_data,
    output logic            asleep
);

    localparam int KW        = AW + 2;
    localparam int SLEEP_CYC = ACC_CYC + SLEEP_MARGIN;

    bus_ctl_t      ctl;
    logic          half_sel;
    logic [KW-1:0] key;
    logic          load_ok;

    pff_ctl_decode u_dec (
        .rst    (rst),
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .we_n   (we_n),
        .byte_n (byte_n),
        .ctl    (ctl)
    );

    // Lane 15 carries the half-word bit only on a narrow bus.
    assign half_sel = ctl.byte_mode & dq_in[DQ_W-1];
    assign key      = {ctl.byte_mode, addr, half_sel};
    assign arr_addr = addr;

    pff_sleep_timer #(
        .KW        (KW),
        .ACC_CYC   (ACC_CYC),
        .SLEEP_CYC (SLEEP_CYC)
    ) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .key     (key),
        .load_ok (load_ok),
        .asleep  (asleep)
    );

    pff_lane_steer u_steer (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (ctl.rd_en),
        .byte_mode (ctl.byte_mode),
        .half_sel  (half_sel),
        .load_ok   (load_ok),
        .hold      (asleep),
        .arr_rdata (arr_rdata),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe)
    );

    assign wr_strobe = ctl.wr_en;
    assign wr_data   = ctl.byte_mode ? {{(DQ_W-BYTE_W){1'b0}}, dq_in[BYTE_W-1:0]} : dq_in;

    // Lanes are never driven while a write is flagged.
    assert_write_no_drive_R5: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> (dq_oe == '0));

    // Output enable high releases every lane.
    assert_oe_release_R4: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (dq_oe == '0));

    // Reset keeps the bus silent.
    always @(negedge clk) begin
        if (rst) begin
            assert_reset_quiet_R6: assert (dq_oe == '0 && !wr_strobe)
                else $error("bus active during reset");
        end
    end

endmodule

// File: tb/sim_pflash_frontend.sv
module sim_pflash_frontend;

    localparam int AW   = 20;
    localparam int ACC  = 4;
    localparam int MARG = 3;
    localparam int SLP  = ACC + MARG;

    logic          clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst = 1'b1;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, byte_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0]   dq_in = '0;
    logic [15:0]   dq_out, dq_oe, wr_data, arr_rdata;
    logic [AW-1:0] arr_addr;
    logic          wr_strobe, asleep;

    logic [15:0]   mem [16];

    pflash_frontend #(.AW(AW), .ACC_CYC(ACC), .SLEEP_MARGIN(MARG)) u0 (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .byte_n(byte_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .arr_addr(arr_addr), .arr_rdata(arr_rdata), .wr_strobe(wr_strobe),
        .wr_data(wr_data), .asleep(asleep)
    );

    // Synchronous array port.
    always @(posedge clk) arr_rdata <= mem[arr_addr[3:0]];

    int total = 0;
    int bad   = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        total++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp_v, $time);
        end
    endtask

    // Behavioural reference state.
    logic [AW+1:0] r_key;
    int            r_cnt = 0;
    logic [15:0]   r_dat = '0;
    logic [15:0]   r_rd  = '0;

    always @(posedge clk) begin
        logic [AW+1:0] k;
        logic          nb;
        nb = !byte_n;
        k  = {nb, addr, nb & dq_in[15]};
        if (rst) begin
            r_cnt = 0;
            r_dat = '0;
        end else begin
            if (k == r_key && r_cnt >= ACC && r_cnt < SLP)
                r_dat = byte_n ? r_rd : {8'h00, (dq_in[15] ? r_rd[15:8] : r_rd[7:0])};
            if (k != r_key) r_cnt = 0;
            else if (r_cnt < SLP) r_cnt = r_cnt + 1;
        end
        r_key = k;
        r_rd  = mem[addr[3:0]];
    end

    // Compare every cycle, away from the clock edge.
    always @(negedge clk) begin
        logic        rd, wr;
        logic [15:0] e_oe, e_wd;
        string       t_oe;
        rd   = !rst && !ce_n && !oe_n && we_n;
        wr   = !rst && !ce_n && !we_n && oe_n;
        e_oe = rd ? (byte_n ? 16'hFFFF : 16'h00FF) : 16'h0000;
        e_wd = byte_n ? dq_in : {8'h00, dq_in[7:0]};
        if (rst)          t_oe = "R6 lanes";
        else if (!rd)     t_oe = "R4 lanes";
        else if (!byte_n) t_oe = "R2 lanes";
        else              t_oe = "R1 lanes";
        chk(t_oe, 32'(dq_oe), 32'(e_oe));
        chk(byte_n ? "R7 latch" : "R3 latch", 32'(dq_out), 32'(r_dat));
        chk("R8 sleep flag", 32'(asleep), 32'(r_cnt == SLP));
        chk("R5 strobe", 32'(wr_strobe), 32'(wr));
        if (wr) chk("R5 data", 32'(wr_data), 32'(e_wd));
        chk("R10 array addr", 32'(arr_addr), 32'(addr));
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic at_neg();
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R7 watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] old3;
        for (int i = 0; i < 16; i++)
            mem[i] = {8'(i * 17 + 1), 8'(i * 5 + 64)};

        // R6: reset state
        tick(3);
        at_neg();
        chk("R6 reset lanes", 32'(dq_oe), 32'h0);
        chk("R6 reset latch", 32'(dq_out), 32'h0);
        rst = 1'b0;

        // Word read, run into sleep, then change the array under it.
        addr = 20'd3; ce_n = 0; oe_n = 0; we_n = 1; byte_n = 1;
        tick(12);
        at_neg();
        chk("R1 word lanes", 32'(dq_oe), 32'hFFFF);
        chk("R8 asleep", 32'(asleep), 32'h1);
        chk("R7 word data", 32'(dq_out), 32'(mem[3]));
        old3 = mem[3];
        tick(1);
        mem[3] = 16'hBEEF;
        tick(4);
        at_neg();
        chk("R8 frozen latch", 32'(dq_out), 32'(old3));

        // R9: wake on address change, new data after the access time.
        tick(1);
        addr = 20'd5;
        @(posedge clk);
        at_neg();
        chk("R9 wake", 32'(asleep), 32'h0);
        repeat (4) @(posedge clk);
        at_neg();
        chk("R7 not yet", 32'(dq_out), 32'(old3));
        @(posedge clk);
        at_neg();
        chk("R7 loaded", 32'(dq_out), 32'(mem[5]));

        // R4: each disabling control
        tick(1); oe_n = 1;
        at_neg(); chk("R4 oe high", 32'(dq_oe), 32'h0);
        tick(1); oe_n = 0; ce_n = 1;
        at_neg(); chk("R4 ce high", 32'(dq_oe), 32'h0);
        tick(1); ce_n = 0; we_n = 0;
        at_neg(); chk("R4 we low", 32'(dq_oe), 32'h0);
        tick(1); we_n = 1;

        // R2, R3: byte mode, low then high half
        tick(1); byte_n = 0; addr = 20'd2; dq_in = 16'h0000;
        tick(9);
        at_neg();
        chk("R2 byte lanes", 32'(dq_oe), 32'h00FF);
        chk("R3 low half", 32'(dq_out), 32'({8'h00, mem[2][7:0]}));
        tick(1); dq_in = 16'h8000;
        tick(9);
        at_neg();
        chk("R3 high half", 32'(dq_out), 32'({8'h00, mem[2][15:8]}));

        // Wake via half-word lane landing around the sleep edge.
        for (int h = SLP - 1; h <= SLP + 1; h++) begin
            tick(h);
            dq_in[15] = ~dq_in[15];
        end
        tick(2);
        byte_n = 1;
        for (int h = SLP - 1; h <= SLP + 1; h++) begin
            tick(h);
            addr = addr + 20'd1;
        end

        // R5: writes in both widths
        tick(1); oe_n = 1; we_n = 0; dq_in = 16'h5A3C;
        at_neg();
        chk("R5 word strobe", 32'(wr_strobe), 32'h1);
        chk("R5 word data", 32'(wr_data), 32'h5A3C);
        tick(1); byte_n = 0;
        at_neg();
        chk("R5 byte data", 32'(wr_data), 32'h003C);
        tick(1); we_n = 1; oe_n = 0; byte_n = 1;

        // R6: reset during an open read
        tick(10); rst = 1;
        at_neg();
        chk("R6 mid-read lanes", 32'(dq_oe), 32'h0);
        tick(1);
        at_neg();
        chk("R6 latch cleared", 32'(dq_out), 32'h0);
        tick(1); rst = 0;

        // Address churn faster than the access time
        for (int j = 0; j < 20; j++) begin
            tick(2);
            addr = 20'(j % 16);
        end
        tick(12);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule